// File: doc/BRIEF.md
# Double-ended PWM driver with rectifier timing skew

The block turns one pulse-width request into drive for a two-switch converter. A cycle pulse starts each switching period and hands the request to output A and output B in turn, so each output is active only on every other period. Two synchronous-rectifier outputs, AN and BN, are the inverses of A and B. Because B is low whenever A is high, BN is high while A conducts, and AN is high while B conducts. When neither switch conducts, both rectifiers are on.

A current-sense trip input ends the active pulse and keeps it off until the next period begins. An 8-bit skew code, read only when a period starts, delays one output group by a whole number of clock cycles. A code below the centre delays A and B. A code above the centre delays AN and BN. A small band around the centre means no delay. This lets the user balance drive paths of unequal length, for example when one group crosses an isolation barrier.

Top module: `dpwm_sr_timing`

## Requirements
- R1: While reset is asserted and right after it is released, A and B are low and AN and BN are high.
- R2: The first period after reset belongs to A. Each `cycle_i` pulse hands the next period to the other output. A and B are never high together.
- R3: With zero skew, the active output follows `pulse_req_i` one clock edge later.
- R4: With zero skew, AN equals NOT A and BN equals NOT B. So BN is high while A is high, AN is high while B is high, and both are high while A and B are low.
- R5: Skew codes 124 to 132 inclusive (centre 128, band of 4 codes on each side) give no delay on any output.
- R6: A code c below 124 delays both edges of A and B by 124−c cycles. The rectifier outputs are not delayed.
- R7: A code c above 132 delays both edges of AN and BN by c−132 cycles. A and B are not delayed.
- R8: The delay saturates at 30 cycles, which is reached at code 94 and below and at code 162 and above.
- R9: The skew code is loaded only in the cycle where `cycle_i` is high. Changes at any other time have no effect until the next `cycle_i`.
- R10: A trip sampled high forces the active output low at the next edge. The pulse stays off for the rest of the period even if the request stays high. A trip sampled together with `cycle_i` blocks the whole new period.
- R11: While A and B are delayed by d cycles, a trip takes d more cycles to end the output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 1 | One-cycle pulse that starts a switching period |
| pulse_req_i | input | 1 | Pulse request for the current period, high = conduct |
| trip_i | input | 1 | Current-sense trip |
| skew_code_i | input | 8 | Skew code, centre 128 |
| pwm_a_o | output | 1 | Drive output A |
| pwm_b_o | output | 1 | Drive output B |
| sr_an_o | output | 1 | Rectifier drive, inverse of A |
| sr_bn_o | output | 1 | Rectifier drive, inverse of B |

## Verification
A trip and the start of a period can arrive in the same clock. The period start clears the trip latch from the old period, while the new trip must still block the new output. The bench raises `cycle_i`, `trip_i` and `pulse_req_i` together. It then judges at the ports that the new output stays low for the whole period and comes back at the following period. A second overlap is a trip landing on a delayed drive group. The bench measures, edge by edge, that the pulse ends exactly d cycles later than in the undelayed case while the rectifier reacts at once.

// File: rtl/dpwm_sr_pkg.sv
`timescale 1ns/1ps
package dpwm_sr_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;

  // clamp a signed step count to 0..max
  function automatic int sat_steps(input int steps, input int max);
    if (steps < 0) return 0;
    if (steps > max) return max;
    return steps;
  endfunction
endpackage

// File: rtl/dpwm_phase_gen.sv
`timescale 1ns/1ps
module dpwm_phase_gen
  import dpwm_sr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_i,
  input  logic req_i,
  input  logic trip_i,
  output logic raw_a_o,
  output logic raw_b_o
);
  phase_e phase_q, phase_d;
  logic   trip_q, trip_d, on_d;
  logic   raw_a_q, raw_b_q;

  always_comb begin
    phase_d = cycle_i ? phase_e'(~phase_q) : phase_q;
    // a new period clears the old latch, a trip in the same cycle re-arms it
    trip_d  = trip_i | (trip_q & ~cycle_i);
    on_d    = req_i & ~trip_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_A;
      trip_q  <= 1'b0;
      raw_a_q <= 1'b0;
      raw_b_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      trip_q  <= trip_d;
      raw_a_q <= on_d & (phase_d == PH_A);
      raw_b_q <= on_d & (phase_d == PH_B);
    end
  end

  assign raw_a_o = raw_a_q;
  assign raw_b_o = raw_b_q;

  a_r10_trip_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> (!raw_a_q && !raw_b_q));
  a_r10_trip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_q && !cycle_i) |=> (!raw_a_q && !raw_b_q));
endmodule

// File: rtl/dpwm_dly_decode.sv
`timescale 1ns/1ps
module dpwm_dly_decode
  import dpwm_sr_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int MID     = 128,
  parameter int DEAD    = 4,
  parameter int MAX_DLY = 30,
  parameter int DLY_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DLY_W-1:0]  pwm_dly_o,
  output logic [DLY_W-1:0]  sr_dly_o
);
  localparam int LO = MID - DEAD;
  localparam int HI = MID + DEAD;

  int code_int;
  logic [DLY_W-1:0] pwm_d, sr_d, pwm_q, sr_q;

  always_comb begin
    code_int = int'(code_i);
    pwm_d    = DLY_W'(sat_steps(LO - code_int, MAX_DLY));
    sr_d     = DLY_W'(sat_steps(code_int - HI, MAX_DLY));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= '0;
      sr_q  <= '0;
    end else if (load_i) begin
      pwm_q <= pwm_d;
      sr_q  <= sr_d;
    end
  end

  assign pwm_dly_o = pwm_q;
  assign sr_dly_o  = sr_q;

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pwm_q) <= MAX_DLY) && (int'(sr_q) <= MAX_DLY));
  a_r5_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((pwm_q != '0) && (sr_q != '0)));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(pwm_q) && $stable(sr_q)));
endmodule

// File: rtl/dpwm_dly_line.sv
`timescale 1ns/1ps
module dpwm_dly_line #(
  parameter int MAX_DLY = 30,
  parameter int DLY_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [DLY_W-1:0] sel_p_i,
  input  logic [DLY_W-1:0] sel_s_i,
  output logic             q_p_o,
  output logic             q_s_o
);
  localparam int TAPS = 1 << DLY_W;

  logic [MAX_DLY-1:0] sh_q;
  logic [TAPS-1:0]    taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[MAX_DLY-2:0], d_i};
  end

  // tap 0 is the undelayed input, tap k is k cycles late
  assign taps  = TAPS'({sh_q, d_i});
  assign q_p_o = taps[sel_p_i];
  assign q_s_o = taps[sel_s_i];
endmodule

// File: rtl/dpwm_sr_timing.sv
`timescale 1ns/1ps
module dpwm_sr_timing #(
  parameter int CODE_W  = 8,
  parameter int MID     = 128,
  parameter int DEAD    = 4,
  parameter int MAX_DLY = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_i,
  input  logic              pulse_req_i,
  input  logic              trip_i,
  input  logic [CODE_W-1:0] skew_code_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              sr_an_o,
  output logic              sr_bn_o
);
  localparam int DLY_W = $clog2(MAX_DLY + 1);
  localparam int LANES = 2;

  logic [LANES-1:0] raw, pwm_tap, sr_tap;
  logic [DLY_W-1:0] pwm_dly, sr_dly;

  dpwm_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cycle_i (cycle_i),
    .req_i   (pulse_req_i),
    .trip_i  (trip_i),
    .raw_a_o (raw[0]),
    .raw_b_o (raw[1])
  );

  dpwm_dly_decode #(
    .CODE_W(CODE_W), .MID(MID), .DEAD(DEAD), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cycle_i),
    .code_i    (skew_code_i),
    .pwm_dly_o (pwm_dly),
    .sr_dly_o  (sr_dly)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpwm_dly_line #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .d_i     (raw[g]),
      .sel_p_i (pwm_dly),
      .sel_s_i (sr_dly),
      .q_p_o   (pwm_tap[g]),
      .q_s_o   (sr_tap[g])
    );
  end

  assign pwm_a_o = pwm_tap[0];
  assign pwm_b_o = pwm_tap[1];
  assign sr_an_o = ~sr_tap[0];
  assign sr_bn_o = ~sr_tap[1];

  a_r4_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_dly == '0 && sr_dly == '0) |-> (sr_an_o != pwm_a_o) && (sr_bn_o != pwm_b_o));
  a_r4_cross_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_dly == '0 && sr_dly == '0) |-> ((!pwm_a_o || sr_bn_o) && (!pwm_b_o || sr_an_o)));
  a_r1_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!pwm_a_o && !pwm_b_o && sr_an_o && sr_bn_o));
endmodule

// File: tb/dpwm_sr_timing_bench.sv
`timescale 1ns/1ps
module dpwm_sr_timing_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, req = 1'b0, trip = 1'b0;
  logic [7:0] code = 8'd128;
  logic a, b, an, bn;
  int n_chk = 0, n_fail = 0;
  bit exp_ph = 1'b0; // 0 = A owns the period

  always #2.5 clk = ~clk;

  dpwm_sr_timing u_dpwm_sr_timing (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cyc), .pulse_req_i(req),
    .trip_i(trip), .skew_code_i(code),
    .pwm_a_o(a), .pwm_b_o(b), .sr_an_o(an), .sr_bn_o(bn)
  );

  // {code, pwm delay, sr delay}
  localparam logic [23:0] VECS [12] = '{
    {8'd128, 8'd0,  8'd0 }, {8'd124, 8'd0,  8'd0 }, {8'd132, 8'd0,  8'd0 },
    {8'd123, 8'd1,  8'd0 }, {8'd133, 8'd0,  8'd1 }, {8'd119, 8'd5,  8'd0 },
    {8'd140, 8'd0,  8'd8 }, {8'd100, 8'd24, 8'd0 }, {8'd94,  8'd30, 8'd0 },
    {8'd0,   8'd30, 8'd0 }, {8'd162, 8'd0,  8'd30}, {8'd255, 8'd0,  8'd30}
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic pw();  return exp_ph ? b : a;   endfunction
  function automatic logic opw(); return exp_ph ? a : b;   endfunction
  function automatic logic sr();  return exp_ph ? bn : an; endfunction

  task automatic new_cycle(input logic [7:0] c);
    cyc = 1'b1; code = c;
    step();
    cyc = 1'b0;
    exp_ph = ~exp_ph;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!a && !b && an && bn, "R1 in reset", {a, b, an, bn}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    check(!a && !b && an && bn, "R1 after release", {a, b, an, bn}, 4'b0011);

    // first period owned by A, zero skew
    req = 1'b1; step();
    check(a && !b, "R2 R3 first period A", {a, b}, 2'b10);
    check(!an && bn, "R4 pairing A/BN", {an, bn}, 2'b01);
    req = 1'b0; step();
    check(!a && an && bn, "R4 freewheel", {a, an, bn}, 3'b011);

    new_cycle(8'd128);
    req = 1'b1; step();
    check(b && !a, "R2 alternate to B", {a, b}, 2'b01);
    check(an && !bn, "R4 pairing B/AN", {an, bn}, 2'b10);
    req = 1'b0; step();

    // delay table: rise and fall edges of both groups
    for (int i = 0; i < 12; i++) begin
      logic [7:0] c;
      int dp, ds, fp, fs;
      bit other;
      string tag;
      c = VECS[i][23:16]; dp = int'(VECS[i][15:8]); ds = int'(VECS[i][7:0]);
      tag = (dp == 30 || ds == 30) ? "R8" : (dp > 0) ? "R6" : (ds > 0) ? "R7" : "R5";
      other = 1'b0;
      req = 1'b0;
      new_cycle(c);
      repeat (35) step();
      req = 1'b1; fp = -1; fs = -1;
      for (int n = 1; n <= 40; n++) begin
        step();
        if (fp < 0 && pw()) fp = n;
        if (fs < 0 && !sr()) fs = n;
        if (opw()) other = 1'b1;
      end
      check(fp == dp + 1, {tag, " pwm rise"}, fp, dp + 1);
      check(fs == ds + 1, {tag, " sr fall"}, fs, ds + 1);
      req = 1'b0; fp = -1; fs = -1;
      for (int n = 1; n <= 40; n++) begin
        step();
        if (fp < 0 && !pw()) fp = n;
        if (fs < 0 && sr()) fs = n;
        if (opw()) other = 1'b1;
      end
      check(fp == dp + 1, {tag, " pwm fall"}, fp, dp + 1);
      check(fs == ds + 1, {tag, " sr rise"}, fs, ds + 1);
      check(!other, "R2 idle output stayed low", other, 0);
    end

    // R9: code change without a period start is ignored
    begin
      int fp;
      req = 1'b0;
      new_cycle(8'd128);
      code = 8'd100;
      repeat (3) step();
      req = 1'b1; step();
      check(pw() == 1'b1, "R9 code ignored mid-period", pw(), 1);
      req = 1'b0; repeat (3) step();
      new_cycle(8'd100);
      repeat (35) step();
      req = 1'b1; fp = -1;
      for (int n = 1; n <= 40; n++) begin
        step();
        if (fp < 0 && pw()) fp = n;
      end
      check(fp == 25, "R9 code taken at period start", fp, 25);
      req = 1'b0; repeat (40) step();
    end

    // R10: trip ends pulse and latches until next period
    new_cycle(8'd128);
    req = 1'b1; repeat (3) step();
    check(pw() == 1'b1, "R10 pulse before trip", pw(), 1);
    trip = 1'b1; step(); trip = 1'b0;
    check(pw() == 1'b0, "R10 trip ends pulse", pw(), 0);
    repeat (5) step();
    check(pw() == 1'b0, "R10 trip latched", pw(), 0);
    new_cycle(8'd128);
    check(pw() == 1'b1, "R10 period start clears latch", pw(), 1);

    // trip together with period start blocks the new period
    cyc = 1'b1; trip = 1'b1; step();
    cyc = 1'b0; trip = 1'b0; exp_ph = ~exp_ph;
    check(pw() == 1'b0 && opw() == 1'b0, "R10 same-cycle trip", {pw(), opw()}, 0);
    repeat (4) step();
    check(pw() == 1'b0, "R10 new period blocked", pw(), 0);
    new_cycle(8'd128);
    check(pw() == 1'b1, "R10 following period resumes", pw(), 1);
    req = 1'b0; step();

    // R11: trip latency grows with PWM delay
    begin
      int fl;
      bit sr_at1;
      new_cycle(8'd119);
      repeat (35) step();
      req = 1'b1; repeat (40) step();
      check(pw() == 1'b1, "R11 delayed pulse high", pw(), 1);
      trip = 1'b1; step(); trip = 1'b0;
      fl = pw() ? -1 : 1;
      sr_at1 = sr();
      for (int n = 2; n <= 12; n++) begin
        step();
        if (fl < 0 && !pw()) fl = n;
      end
      check(fl == 6, "R11 trip latency", fl, 6);
      check(sr_at1 == 1'b1, "R11 rectifier undelayed on trip", sr_at1, 1);
      req = 1'b0;
      new_cycle(8'd128);
      repeat (35) step();
    end

    summary();
  end
endmodule